// File: doc/BRIEF.md
# Buffered 16-bit timer/counter

This block is a bus-mapped 16-bit up-counter. Three byte-wide registers sit on a small register bus: a control byte, the low count byte and the high count byte. The counter can advance on every system clock, on every fourth system clock, or on rising edges of an external signal. The external signal comes either from a general input pin or from a secondary-oscillator input, picked by a control bit. A power-of-two prescaler sits between the chosen source and the counter. The external signal can pass through a two-flop synchronizer, or it can skip it for lower latency.

When the counter wraps from all ones to zero it sets a sticky overflow flag, which stays set until a clear strobe. A pulse from a neighbouring compare unit clears the count. In buffered mode the two count bytes act as one 16-bit value: a read of the low byte captures the high byte into a holding register, and a write of the high byte is held back until the low byte is written. Software then sees, and loads, a coherent 16-bit value.

Top module: `timer16_unit`

## Requirements
- R1: Control byte at address 0: bits [7:6] source select, [5:4] prescale select, bit 3 oscillator-input select, bit 2 synchronizer bypass, bit 1 buffered mode, bit 0 run. It reads back as written and is 0x00 after reset, as are both count bytes and the overflow flag. Address 3 reads 0x00.
- R2: Source 00 advances the count once every four system clocks, and source 01 on every system clock. The four-clock phase restarts on any count write or clear pulse, so the first advance falls on the fourth clock after the write.
- R3: Source 10 counts rising edges of `ext_pin` when bit 3 is 0 and of `osc_in` when bit 3 is 1. The input that is not selected is ignored. Source 11 never advances the count.
- R4: Prescale select 00/01/10/11 advances the count once per 1/2/4/8 source ticks.
- R5: With bit 2 at 0, a rise on the selected external input that is set up before clock edge A is counted at edge A+2. With bit 2 at 1 it is counted at edge A.
- R6: With run at 0 the count holds its value, and the prescaler does not advance.
- R7: A wrap from 0xFFFF to 0x0000 sets `ovf_flag` at that edge. The flag stays set until `ovf_clr` is high at an edge. If a wrap and a clear fall on the same edge, the flag is set.
- R8: `evt_reset` high at an edge sets the count to 0x0000. It takes priority over a bus write and over counting at that edge.
- R9: In byte mode (bit 1 = 0), a write to address 1 or 2 loads only that byte of the count, and address 2 reads the live high byte.
- R10: In buffered mode a read of address 1 copies the high byte in effect at that edge into a holding register, and address 2 then reads that holding register.
- R11: In buffered mode a write to address 2 loads only the holding register and leaves the count alone. A write to address 1 loads {holding register, written byte} into the count at one edge.
- R12: Any count write and any `evt_reset` restart the prescaler's division, so a partial prescale run before the write does not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures the high byte in buffered mode) |
| bus_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_pin | input | 1 | External count input |
| osc_in | input | 1 | Secondary-oscillator count input |
| evt_reset | input | 1 | Clear-count pulse from the compare unit |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Read data is combinational, so a register value can be sampled before the edge that follows it. A count loaded or cleared at an edge is visible right after that edge. An internal-source advance takes effect at the edge where the run bit is already set, so the edge that sets run does not count. An external rise is counted three edges after it is driven when synchronized and one edge after it is driven when bypassed. The overflow flag is up right after the wrap edge. The bench drives on the falling edge and samples one time step later. It counts its wait cycles from the write edge that restarts the dividers and gives each check exactly the edge count these latencies call for. The synchronized-input check samples once at two edges, where the count must not yet have moved, and again at three edges.

// File: rtl/timer16_pkg.sv
// Package: shared types and constants for the buffered 16-bit timer.
// Assumes a byte-wide register bus with a 2-bit address.
package timer16_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_NONE  = 2'b11
    } src_e;

    typedef struct packed {
        src_e       src;
        logic [1:0] ps;
        logic       osc_en;
        logic       nosync;
        logic       mode16;
        logic       run;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd2;
endpackage

// File: rtl/timer16_edge.sv
// Module: timer16_edge
// Picks one of two external inputs and turns its rising edges into one-cycle
// pulses in the clk domain, either through a SYNC_STAGES-deep synchronizer
// or through a single sampling flop when bypass is set.
// Assumes: inputs may be asynchronous; bypass is only safe for clk-aligned inputs.
module timer16_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic sel_b,
    input  logic bypass,
    output logic rise
);
    logic                   raw;
    logic [SYNC_STAGES-1:0] sreg;
    logic                   sdel;

    // Select the active external input.
    assign raw = sel_b ? pin_b : pin_a;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sreg <= '0;
                else        sreg <= {sreg[SYNC_STAGES-2:0], raw};
            end
        end else begin : g_single
            // Single sampling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sreg <= '0;
                else        sreg <= raw;
            end
        end
    endgenerate

    // Delay the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sdel <= 1'b0;
        else        sdel <= sreg[SYNC_STAGES-1];
    end

    // Edge pulse: raw against its first sample, or synchronized against its delay.
    assign rise = bypass ? (raw & ~sreg[0]) : (sreg[SYNC_STAGES-1] & ~sdel);

    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (!rise || sel_b != $past(sel_b) || bypass != $past(bypass)));
endmodule

// File: rtl/timer16_tick.sv
// Module: timer16_tick
// Chooses the raw count tick: clk/INSTR_DIV, every clk, external edge, or none.
// The clk/INSTR_DIV phase restarts on clr.
// Assumes: INSTR_DIV is a power of two.
module timer16_tick
    import timer16_pkg::*;
#(
    parameter int INSTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_rise,
    input  logic clr,
    output logic tick
);
    localparam int DIV_W = $clog2(INSTR_DIV);

    logic [DIV_W-1:0] phase;

    // Free-running divider phase, restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase <= '0;
        else               phase <= phase + 1'b1;
    end

    // Source multiplexer.
    always_comb begin
        unique case (src)
            SRC_INSTR: tick = &phase;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT:   tick = ext_rise;
            default:   tick = 1'b0;
        endcase
    end

    assert_instr_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INSTR && tick && !clr) |=> !tick);
endmodule

// File: rtl/timer16_prescale.sv
// Module: timer16_prescale
// Passes one advance per 2**ps source ticks while run is set.
// Assumes: clr restarts the division; ps changes take effect immediately.
module timer16_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    input  logic            clr,
    output logic            adv
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    logic             full;
    logic             tick_en;

    // Decode the ratio into a mask of low counter bits.
    assign mask    = PRE_W'((1 << ps) - 1);
    assign full    = ((pre_cnt & mask) == mask);
    assign tick_en = tick && run;
    assign adv     = tick_en && full;

    // Division counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pre_cnt <= '0;
        else if (tick_en)   pre_cnt <= full ? '0 : pre_cnt + 1'b1;
    end

    assert_ratio_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ps == '0 && tick && run) |-> adv);
    assert_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_cnt));
endmodule

// File: rtl/timer16_core.sv
// Module: timer16_core
// The count register and its sticky overflow flag. Priority per edge:
// clear pulse, then load, then advance.
// Assumes: adv is a single-cycle enable from the prescaler.
module timer16_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         evt,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         ovf_flag
);
    logic wrap;

    assign wrap = adv && !evt && !ld_en && (&count);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || evt) count <= '0;
        else if (ld_en)    count <= ld_val;
        else if (adv)      count <= count + 1'b1;
    end

    // Sticky overflow flag; a new wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    assert_evt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (count == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !evt && !ld_en) |=> $stable(count));
    assert_ovf_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(count) == '1));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/timer16_unit.sv
// Module: timer16_unit (top)
// Byte-wide register front end of the 16-bit timer: control byte, count bytes,
// high-byte holding register for buffered access, and source wiring.
// Assumes: one bus access per cycle; read data is combinational from bus_addr.
module timer16_unit
    import timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INSTR_DIV   = 4,
    parameter int PS_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_pin,
    input  logic              osc_in,
    input  logic              evt_reset,
    input  logic              ovf_clr,
    output logic              ovf_flag
);
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] hbuf;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  ld_val;
    logic              wr_ctrl, wr_lo, wr_hi, rd_lo;
    logic              ld_en, div_clr;
    logic              ext_rise, tick, adv;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_lo   = bus_wr && (bus_addr == A_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_HI);
    assign rd_lo   = bus_rd && (bus_addr == A_LO);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
    end

    // High-byte holding register for buffered access.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hbuf <= '0;
        else if (ctrl.mode16 && wr_hi) hbuf <= bus_wdata;
        else if (ctrl.mode16 && rd_lo) hbuf <= count[CNT_W-1:BYTE_W];
    end

    // Load request and value for the count register.
    always_comb begin
        ld_en  = wr_lo || (wr_hi && !ctrl.mode16);
        ld_val = count;
        if (wr_lo && ctrl.mode16)  ld_val = {hbuf, bus_wdata};
        else if (wr_lo)            ld_val = {count[CNT_W-1:BYTE_W], bus_wdata};
        else if (wr_hi)            ld_val = {bus_wdata, count[BYTE_W-1:0]};
    end

    assign div_clr = ld_en || evt_reset;

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl;
            A_LO:    bus_rdata = count[BYTE_W-1:0];
            A_HI:    bus_rdata = ctrl.mode16 ? hbuf : count[CNT_W-1:BYTE_W];
            default: bus_rdata = '0;
        endcase
    end

    timer16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_a  (ext_pin),
        .pin_b  (osc_in),
        .sel_b  (ctrl.osc_en),
        .bypass (ctrl.nosync),
        .rise   (ext_rise)
    );

    timer16_tick #(.INSTR_DIV(INSTR_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (ctrl.src),
        .ext_rise (ext_rise),
        .clr      (div_clr),
        .tick     (tick)
    );

    timer16_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (ctrl.run),
        .ps    (ctrl.ps),
        .clr   (div_clr),
        .adv   (adv)
    );

    timer16_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .evt      (evt_reset),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    assert_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode16 && rd_lo && !bus_wr) |=> (hbuf == $past(count[CNT_W-1:BYTE_W])));
    assert_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode16 && wr_lo && !evt_reset) |=> (count == {$past(hbuf), $past(bus_wdata)}));
    assert_hi_only_buf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode16 && wr_hi && !evt_reset && !adv) |=> $stable(count));
endmodule

// File: tb/test_timer16_unit.sv
module test_timer16_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0, osc_in = 1'b0, evt_reset = 1'b0, ovf_clr = 1'b0;
    logic       ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer16_unit i_timer16_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .osc_in(osc_in), .evt_reset(evt_reset),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    // Vector: {ctrl[47:40], preset[39:24], run edges[23:16], expected[15:0]}
    localparam logic [47:0] VEC [9] = '{
        {8'h41, 16'h0100, 8'd10, 16'h010A},  // R2 every clock
        {8'h51, 16'h2000, 8'd9,  16'h2004},  // R4 ratio 2
        {8'h61, 16'h00FE, 8'd12, 16'h0101},  // R4 ratio 4, byte carry
        {8'h71, 16'h1234, 8'd17, 16'h1236},  // R4 ratio 8
        {8'h01, 16'h0000, 8'd11, 16'h0003},  // R2 clock/4: (n+1)/4
        {8'h11, 16'h0F00, 8'd15, 16'h0F02},  // R2 clock/4 with ratio 2
        {8'hC1, 16'hABCD, 8'd8,  16'hABCD},  // R3 source 11 idle
        {8'h40, 16'h7777, 8'd8,  16'h7777},  // R6 run off holds
        {8'h81, 16'h0042, 8'd5,  16'h0042}   // R3 external, no edges
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic preset(input logic [15:0] v);
        wr(2'd2, v[15:8]);
        wr(2'd1, v[7:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lo, hi, b;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, b);  check("R1", "ctrl reset", {8'h0, b}, 16'h0000);
        peek(2'd1, lo); peek(2'd2, hi);
        check("R1", "count reset", {hi, lo}, 16'h0000);
        check("R1", "flag reset", {15'h0, ovf_flag}, 16'h0000);
        // R1 readback and unused address
        wr(2'd0, 8'hAE);
        peek(2'd0, b);  check("R1", "ctrl readback", {8'h0, b}, 16'h00AE);
        peek(2'd3, b);  check("R1", "addr 3", {8'h0, b}, 16'h0000);
        wr(2'd0, 8'h00);

        // Vector walk
        for (int i = 0; i < 9; i++) begin
            preset(VEC[i][39:24]);
            wr(2'd0, VEC[i][47:40]);
            cyc(int'(VEC[i][23:16]) - 1);
            wr(2'd0, VEC[i][47:40] & 8'hFE);
            rd(2'd1, lo); rd(2'd2, hi);
            check("R2/R3/R4/R6", $sformatf("vector %0d", i), {hi, lo}, VEC[i][15:0]);
        end
        wr(2'd0, 8'h00);

        // R9 byte access
        preset(16'h5AC3);
        wr(2'd2, 8'h11);
        peek(2'd1, lo); peek(2'd2, hi);
        check("R9", "high byte only", {hi, lo}, 16'h11C3);

        // R11 buffered write
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h9B);
        rd(2'd1, lo); rd(2'd2, hi);
        check("R11", "high write held", {hi, lo}, 16'h11C3);
        wr(2'd2, 8'h9B); wr(2'd1, 8'h7E);
        wr(2'd0, 8'h00);
        peek(2'd1, lo); peek(2'd2, hi);
        check("R11", "commit", {hi, lo}, 16'h9B7E);

        // R10 buffered read across a byte carry
        preset(16'h00FE);
        wr(2'd0, 8'h43);
        rd(2'd1, lo); rd(2'd2, hi);
        check("R10", "coherent pair", {hi, lo}, 16'h00FE);
        wr(2'd0, 8'h00);

        // R7 overflow
        preset(16'hFFFE);
        wr(2'd0, 8'h41);
        cyc(2);
        check("R7", "flag on wrap", {15'h0, ovf_flag}, 16'h0001);
        wr(2'd0, 8'h00);
        cyc(5);
        check("R7", "flag sticky", {15'h0, ovf_flag}, 16'h0001);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R7", "flag cleared", {15'h0, ovf_flag}, 16'h0000);

        // R8 clear pulse, also against a write
        preset(16'h5555);
        evt_reset = 1'b1; @(negedge clk); evt_reset = 1'b0;
        peek(2'd1, lo); peek(2'd2, hi);
        check("R8", "clear", {hi, lo}, 16'h0000);
        preset(16'h3333);
        evt_reset = 1'b1; wr(2'd1, 8'h22); evt_reset = 1'b0;
        peek(2'd1, lo); peek(2'd2, hi);
        check("R8", "clear beats write", {hi, lo}, 16'h0000);

        // R5/R3 external source, synchronized
        wr(2'd0, 8'h81);
        ext_pin = 1'b1;
        cyc(2); peek(2'd1, lo);
        check("R5", "sync not yet", {8'h0, lo}, 16'h0000);
        cyc(1); peek(2'd1, lo);
        check("R5", "sync at third edge", {8'h0, lo}, 16'h0001);
        ext_pin = 1'b0; cyc(4);
        // R5 bypassed
        wr(2'd0, 8'h85);
        ext_pin = 1'b1;
        cyc(1); peek(2'd1, lo);
        check("R5", "bypass first edge", {8'h0, lo}, 16'h0002);
        ext_pin = 1'b0; cyc(4);
        // R3 oscillator input selected, pin ignored
        wr(2'd0, 8'h89);
        ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4);
        peek(2'd1, lo);
        check("R3", "pin ignored", {8'h0, lo}, 16'h0002);
        osc_in = 1'b1; cyc(4); osc_in = 1'b0; cyc(2);
        peek(2'd1, lo);
        check("R3", "osc counted", {8'h0, lo}, 16'h0003);
        wr(2'd0, 8'h00);

        // R12 prescaler restart on write
        preset(16'h0000);
        wr(2'd0, 8'h71);
        cyc(5);
        wr(2'd1, 8'h00);
        cyc(7); peek(2'd1, lo);
        check("R12", "partial run dropped", {8'h0, lo}, 16'h0000);
        cyc(1); peek(2'd1, lo);
        check("R4", "eighth tick", {8'h0, lo}, 16'h0001);
        wr(2'd0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule